// File: doc/BRIEF.md
# Sampling Performance Counter Unit

This unit holds six 32-bit counters that count upward, one step per clock, on events picked from a shared event bus. Software reaches every control word, every counter and a sampled-address capture through one register port. The port has a write strobe, a 10-bit address, write data and combinational read data.

Three things gate counting. A global freeze bit stops everything. Two privilege bits freeze counting in supervisor state or in user state. Two mark bits freeze counting while the process mark input is 1 or while it is 0. A counter with bit 31 set has an overflow condition, and that condition counts only while its enable bit is set. Software can preload a counter with 0x80000000 minus N to get an overflow after N events.

Once the overflow condition exists, the unit can do three things. It can raise an interrupt request. It can sample the current instruction address into a read-only capture register. It can also stop all counting at once and set the global freeze bit in hardware. A two-state machine tracks the interrupt. In ARMED the request is low. The transition ARMED->SAMPLED is taken when the interrupt is enabled and an enabled overflow exists, and this transition also latches the address. In SAMPLED the request is high. The transition SAMPLED->ARMED is taken as soon as that condition goes away.

Top module: `pmu_sampler`

## Requirements
- R1: After reset, control word 0 reads 0x80000000 (global freeze set), and control words 1 and 2, all six counters and the capture register read 0. The interrupt request is low.
- R2: The register map is as follows. Control 0 is at address 952, control 1 at 956 and control 2 at 944. Counters 1 to 6 are at 953, 954, 957, 958, 945 and 946. The capture register is at 955. Control 2 is plain read/write storage. Writes to the capture register are ignored. Unmapped addresses read 0.
- R3: Each counter has an event selector. Counter 1 uses control 0 bits 12:6 and counter 2 uses control 0 bits 5:0. Counter 3 uses control 1 bits 31:27, counter 4 bits 26:22, counter 5 bits 21:17 and counter 6 bits 16:11. With selector value s between 1 and EVT_W-1, the counter adds exactly one on each unfrozen clock in which evt_bus[s] is 1. Selector value 0, or any value of EVT_W or more, never counts.
- R4: While control 0 bit 31 is 1, no counter changes except through a register write.
- R5: Control 0 bit 30 freezes counting while priv_sup is 1. Bit 29 freezes counting while priv_sup is 0.
- R6: Control 0 bit 28 freezes counting while mark_bit is 1. Bit 27 freezes counting while mark_bit is 0.
- R7: A register write to a counter in the same cycle as a counted event loads exactly the written value. Counting resumes from that value on the next clock.
- R8: An overflow condition exists when counter 1 has bit 31 set and control 0 bit 15 is 1. It also exists when any of counters 2 to 6 has bit 31 set and control 0 bit 14 is 1.
- R9: The interrupt request rises one clock after the overflow condition first coexists with control 0 bit 26. It stays high while both hold. It falls one clock after either one goes away, whether because software rewrote the counter or cleared bit 26.
- R10: The capture register takes the value of inst_addr at the clock edge on which the interrupt request rises. It holds that value at every other edge.
- R11: While control 0 bit 25 is 1 and an overflow condition exists, all counting stops in that same cycle. Control 0 bit 31 is then set at the next edge, unless control 0 is written in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 10 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |
| evt_bus | input | EVT_W | Event inputs, bit s selected by selector value s |
| priv_sup | input | 1 | 1 = supervisor state, 0 = user state |
| mark_bit | input | 1 | Process mark input |
| inst_addr | input | 32 | Current instruction address |
| pm_irq | output | 1 | Performance-monitor interrupt request |

## Verification
The hardest situation to reach is the overflow edge itself. This is the cycle where a counter steps into bit 31 while the freeze-on-overflow bit is set. The unit has to stop counting in that cycle, set the global freeze at the next edge, raise the request and sample the address, all at once. The stimulus gets there by preloading counters through the register port to 0x80000000 minus a small N. It then holds the selected event high and changes inst_addr at every clock, so the exact capture edge and stop value can be checked. The freeze gating is swept exhaustively over all 32 settings of the five freeze bits, for both privilege states and both mark values.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
    localparam int unsigned ADDR_W  = 10;
    localparam int unsigned CNT_W   = 32;
    localparam int unsigned NUM_CNT = 6;
    localparam int unsigned SEL_W   = 7;

    localparam logic [ADDR_W-1:0] A_CTL0 = 10'd952;
    localparam logic [ADDR_W-1:0] A_CTL1 = 10'd956;
    localparam logic [ADDR_W-1:0] A_CTL2 = 10'd944;
    localparam logic [ADDR_W-1:0] A_SIAR = 10'd955;

    localparam int unsigned B_FRZ_ALL = 31;
    localparam int unsigned B_FRZ_SUP = 30;
    localparam int unsigned B_FRZ_USR = 29;
    localparam int unsigned B_FRZ_M1  = 28;
    localparam int unsigned B_FRZ_M0  = 27;
    localparam int unsigned B_IRQ_EN  = 26;
    localparam int unsigned B_FRZ_OVF = 25;
    localparam int unsigned B_CE_1    = 15;
    localparam int unsigned B_CE_N    = 14;

    localparam logic [CNT_W-1:0] CTL0_RESET = 32'h8000_0000;

    typedef enum logic {
        ST_ARMED,
        ST_SAMPLED
    } pmu_state_t;

    function automatic logic [ADDR_W-1:0] cnt_addr(input int unsigned idx);
        case (idx)
            0:       return 10'd953;
            1:       return 10'd954;
            2:       return 10'd957;
            3:       return 10'd958;
            4:       return 10'd945;
            default: return 10'd946;
        endcase
    endfunction

    function automatic logic [SEL_W-1:0] sel_field(input int unsigned idx,
                                                   input logic [31:0] c0,
                                                   input logic [31:0] c1);
        case (idx)
            0:       return c0[12:6];
            1:       return {1'b0, c0[5:0]};
            2:       return {2'b0, c1[31:27]};
            3:       return {2'b0, c1[26:22]};
            4:       return {2'b0, c1[21:17]};
            default: return {1'b0, c1[16:11]};
        endcase
    endfunction
endpackage

// File: rtl/pmu_event_counter.sv
module pmu_event_counter #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned EVT_W = 64,
    parameter int unsigned SEL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic [EVT_W-1:0] evt_bus,
    input  logic             cnt_en,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cnt
);
    localparam int unsigned PAD_W = 1 << SEL_W;

    logic [PAD_W-1:0] evt_pad;
    logic             hit;

    always_comb begin
        evt_pad = PAD_W'(evt_bus);
        hit     = (sel != '0) && evt_pad[sel];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_en)
            cnt <= wr_data;
        else if (cnt_en && hit)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pmu_irq_fsm.sv
module pmu_irq_fsm #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_cond,
    input  logic [AW-1:0] inst_addr,
    output logic          pm_irq,
    output logic [AW-1:0] siar
);
    import pmu_pkg::*;

    pmu_state_t state_q, state_d;
    logic       capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            siar    <= '0;
        end else begin
            state_q <= state_d;
            if (capture)
                siar <= inst_addr;
        end
    end

    always_comb begin
        state_d = state_q;
        capture = 1'b0;
        pm_irq  = 1'b0;
        unique case (state_q)
            ST_ARMED: begin
                if (irq_cond) begin
                    state_d = ST_SAMPLED;
                    capture = 1'b1;
                end
            end
            ST_SAMPLED: begin
                pm_irq = 1'b1;
                if (!irq_cond)
                    state_d = ST_ARMED;
            end
        endcase
    end
endmodule

// File: rtl/pmu_sampler.sv
module pmu_sampler #(
    parameter int unsigned EVT_W = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [9:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [EVT_W-1:0] evt_bus,
    input  logic        priv_sup,
    input  logic        mark_bit,
    input  logic [31:0] inst_addr,
    output logic        pm_irq
);
    import pmu_pkg::*;

    logic [31:0] cr0_q, cr1_q, cr2_q, siar;
    logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q;
    logic ovf_cond, irq_cond, frz, wr_cr0;

    assign wr_cr0 = reg_we && (reg_addr == A_CTL0);

    always_comb begin
        ovf_cond = cr0_q[B_CE_1] && cnt_q[0][CNT_W-1];
        for (int i = 1; i < NUM_CNT; i++)
            ovf_cond = ovf_cond || (cr0_q[B_CE_N] && cnt_q[i][CNT_W-1]);
        irq_cond = cr0_q[B_IRQ_EN] && ovf_cond;
        frz = cr0_q[B_FRZ_ALL]
            || (cr0_q[B_FRZ_OVF] && ovf_cond)
            || (cr0_q[B_FRZ_SUP] &&  priv_sup)
            || (cr0_q[B_FRZ_USR] && !priv_sup)
            || (cr0_q[B_FRZ_M1]  &&  mark_bit)
            || (cr0_q[B_FRZ_M0]  && !mark_bit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cr0_q <= CTL0_RESET;
            cr1_q <= '0;
            cr2_q <= '0;
        end else begin
            if (wr_cr0)
                cr0_q <= reg_wdata;
            else if (cr0_q[B_FRZ_OVF] && ovf_cond)
                cr0_q[B_FRZ_ALL] <= 1'b1;
            if (reg_we && reg_addr == A_CTL1)
                cr1_q <= reg_wdata;
            if (reg_we && reg_addr == A_CTL2)
                cr2_q <= reg_wdata;
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        pmu_event_counter #(
            .CNT_W(CNT_W),
            .EVT_W(EVT_W),
            .SEL_W(SEL_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (sel_field(g, cr0_q, cr1_q)),
            .evt_bus (evt_bus),
            .cnt_en  (!frz),
            .wr_en   (reg_we && (reg_addr == cnt_addr(g))),
            .wr_data (reg_wdata),
            .cnt     (cnt_q[g])
        );
    end

    pmu_irq_fsm #(.AW(32)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_cond  (irq_cond),
        .inst_addr (inst_addr),
        .pm_irq    (pm_irq),
        .siar      (siar)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTL0:  reg_rdata = cr0_q;
            A_CTL1:  reg_rdata = cr1_q;
            A_CTL2:  reg_rdata = cr2_q;
            A_SIAR:  reg_rdata = siar;
            default: reg_rdata = '0;
        endcase
        for (int i = 0; i < NUM_CNT; i++)
            if (reg_addr == cnt_addr(i))
                reg_rdata = cnt_q[i];
    end
endmodule

// File: rtl/pmu_sampler_chk.sv
module pmu_sampler_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        reg_we,
    input logic [9:0]  reg_addr,
    input logic [31:0] cr0,
    input logic        ovf_cond,
    input logic        frz,
    input logic [31:0] cnt1,
    input logic [31:0] siar,
    input logic        pm_irq
);
    import pmu_pkg::*;

    logic wr_c1, wr_c0;
    assign wr_c1 = reg_we && (reg_addr == cnt_addr(0));
    assign wr_c0 = reg_we && (reg_addr == A_CTL0);

    // R4: a frozen counter only changes through a write
    a_r4_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frz && !wr_c1) |=> $stable(cnt1));

    // R3: a counter steps by at most one per clock
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_c1 |=> (cnt1 == $past(cnt1) || cnt1 == $past(cnt1) + 32'd1));

    // R9: request rises only after an enabled overflow with the interrupt enabled
    a_r9_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pm_irq) |-> $past(cr0[B_IRQ_EN] && ovf_cond));

    // R9: request drops once the condition is gone
    a_r9_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (pm_irq && !(cr0[B_IRQ_EN] && ovf_cond)) |=> !pm_irq);

    // R10: capture register changes only with a rising request
    a_r10_siar_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(pm_irq) |-> $stable(siar));

    // R11: hardware sets the global freeze on an overflow
    a_r11_hw_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (cr0[B_FRZ_OVF] && ovf_cond && !wr_c0) |=> cr0[B_FRZ_ALL]);
endmodule

bind pmu_sampler pmu_sampler_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .cr0      (cr0_q),
    .ovf_cond (ovf_cond),
    .frz      (frz),
    .cnt1     (cnt_q[0]),
    .siar     (siar),
    .pm_irq   (pm_irq)
);

// File: tb/pmu_sampler_bench.sv
`timescale 1ns/1ps
module pmu_sampler_bench;
    localparam int EVT_W = 64;
    localparam logic [9:0] CTL0 = 10'd952, CTL1 = 10'd956, CTL2 = 10'd944, SIAR = 10'd955;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [EVT_W-1:0] evt_bus = '0;
    logic        priv_sup = 1'b0;
    logic        mark_bit = 1'b0;
    logic [31:0] inst_addr = '0;
    logic        pm_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pmu_sampler #(.EVT_W(EVT_W)) u_pmu_sampler (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_bus(evt_bus),
        .priv_sup(priv_sup), .mark_bit(mark_bit), .inst_addr(inst_addr),
        .pm_irq(pm_irq)
    );

    function automatic logic [9:0] caddr(input int c);
        case (c)
            0: return 10'd953;
            1: return 10'd954;
            2: return 10'd957;
            3: return 10'd958;
            4: return 10'd945;
            default: return 10'd946;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(CTL0, v); chk("R1 ctl0", v, 32'h8000_0000);
        rd(CTL1, v); chk("R1 ctl1", v, 32'h0);
        rd(CTL2, v); chk("R1 ctl2", v, 32'h0);
        rd(SIAR, v); chk("R1 siar", v, 32'h0);
        for (int c = 0; c < 6; c++) begin
            rd(caddr(c), v); chk("R1 counter", v, 32'h0);
        end
        chk("R1 irq", {31'b0, pm_irq}, 32'h0);

        // R2 map behaviour
        wr(CTL2, 32'hDEAD_BEEF);
        rd(CTL2, v); chk("R2 ctl2 storage", v, 32'hDEAD_BEEF);
        wr(SIAR, 32'h1234_5678);
        rd(SIAR, v); chk("R2 siar write ignored", v, 32'h0);
        rd(10'd0, v); chk("R2 unmapped", v, 32'h0);
        wr(caddr(5), 32'h0000_0042);
        rd(caddr(5), v); chk("R2 counter6 address", v, 32'h0000_0042);
        wr(caddr(5), 32'h0);

        // R4 R5 R6 exhaustive freeze sweep on counter 1, selector 1
        for (int m = 0; m < 32; m++) begin
            for (int p = 0; p < 2; p++) begin
                for (int k = 0; k < 2; k++) begin
                    logic frozen;
                    evt_bus = '0;
                    priv_sup = p[0];
                    mark_bit = k[0];
                    wr(CTL0, {m[4:0], 27'b0} | 32'h0000_0040);
                    wr(caddr(0), 32'h0);
                    evt_bus = 64'h2;
                    repeat (3) @(negedge clk);
                    evt_bus = '0;
                    frozen = m[4] | (m[3] & p[0]) | (m[2] & ~p[0]) |
                             (m[1] & k[0]) | (m[0] & ~k[0]);
                    rd(caddr(0), v);
                    chk("R4 R5 R6 freeze gating", v, frozen ? 32'd0 : 32'd3);
                end
            end
        end

        // R3 selector sweep on each counter
        priv_sup = 1'b0; mark_bit = 1'b0;
        for (int c = 0; c < 6; c++) begin
            int maxs;
            maxs = (c == 0) ? 127 : ((c == 1 || c == 5) ? 63 : 31);
            for (int t = 0; t < 4; t++) begin
                int s;
                logic [31:0] c0, c1;
                logic [63:0] oh;
                s = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 7 : maxs;
                c0 = 32'h0; c1 = 32'h0;
                case (c)
                    0: c0 = 32'(s) << 6;
                    1: c0 = 32'(s);
                    2: c1 = 32'(s) << 27;
                    3: c1 = 32'(s) << 22;
                    4: c1 = 32'(s) << 17;
                    default: c1 = 32'(s) << 11;
                endcase
                evt_bus = '0;
                wr(CTL0, c0);
                wr(CTL1, c1);
                wr(caddr(c), 32'h0);
                oh = (s < 64) ? (64'd1 << s) : 64'd0;
                evt_bus = oh;
                repeat (2) @(negedge clk);
                evt_bus = ~oh;
                repeat (2) @(negedge clk);
                evt_bus = '0;
                rd(caddr(c), v);
                chk("R3 selector", v, (s != 0 && s < 64) ? 32'd2 : 32'd0);
            end
        end

        // R7 write wins over increment
        wr(CTL1, 32'h0);
        wr(CTL0, 32'h0000_0003);
        evt_bus = 64'h8;
        wr(caddr(1), 32'h0000_1234);
        rd(caddr(1), v); chk("R7 write priority", v, 32'h0000_1234);
        @(negedge clk);
        rd(caddr(1), v); chk("R7 resume count", v, 32'h0000_1235);
        evt_bus = '0;
        wr(caddr(1), 32'h0);

        // R9 R10 interrupt and capture on counter 1, no hardware freeze
        wr(CTL0, 32'h0400_8040);
        wr(caddr(0), 32'h7FFF_FFFD);
        inst_addr = 32'h0000_1000;
        evt_bus = 64'h2;
        @(negedge clk); inst_addr = 32'h0000_1001;
        @(negedge clk); inst_addr = 32'h0000_1002;
        @(negedge clk);
        rd(caddr(0), v); chk("R8 counter reaches bit31", v, 32'h8000_0000);
        chk("R9 irq latency", {31'b0, pm_irq}, 32'h0);
        inst_addr = 32'hCAFE_0000;
        @(negedge clk);
        chk("R9 irq raised", {31'b0, pm_irq}, 32'h1);
        rd(SIAR, v); chk("R10 capture value", v, 32'hCAFE_0000);
        rd(caddr(0), v); chk("R9 counting continues", v, 32'h8000_0001);
        inst_addr = 32'h0000_1111;
        evt_bus = '0;
        @(negedge clk);
        rd(SIAR, v); chk("R10 capture hold", v, 32'hCAFE_0000);
        chk("R9 irq held", {31'b0, pm_irq}, 32'h1);
        wr(caddr(0), 32'h0);
        chk("R9 irq before drop", {31'b0, pm_irq}, 32'h1);
        @(negedge clk);
        chk("R9 irq dropped", {31'b0, pm_irq}, 32'h0);

        // R8 enable bits: counter 5 needs bit 14
        wr(CTL0, 32'h0400_8000);
        wr(caddr(4), 32'h8000_0000);
        @(negedge clk);
        chk("R8 group enable off", {31'b0, pm_irq}, 32'h0);
        wr(CTL0, 32'h0400_4000);
        chk("R8 before rise", {31'b0, pm_irq}, 32'h0);
        @(negedge clk);
        chk("R8 group enable on", {31'b0, pm_irq}, 32'h1);
        wr(CTL0, 32'h0000_4000);
        @(negedge clk);
        chk("R9 enable cleared", {31'b0, pm_irq}, 32'h0);
        wr(caddr(4), 32'h0);

        // R11 hardware freeze on counter 5, selector 2
        wr(CTL1, 32'h2 << 17);
        wr(CTL0, 32'h0600_4000);
        wr(caddr(4), 32'h7FFF_FFFE);
        evt_bus = 64'h4;
        repeat (4) @(negedge clk);
        rd(caddr(4), v); chk("R11 stop at overflow", v, 32'h8000_0000);
        rd(CTL0, v); chk("R11 freeze bit set", v, 32'h8600_4000);
        chk("R11 irq", {31'b0, pm_irq}, 32'h1);
        evt_bus = '0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule